// File: doc/BRIEF.md
# DS3 Transmit Frame Reference Generator

This block provides the terminal-side timing on the transmit path of a DS3 mapper. It runs from the 44.736 MHz transmit bit clock and keeps a frame position counter. The frame is built from 85-bit blocks, and the first bit of each block is an overhead bit. From the counter the block derives a nibble clock that stops for every overhead bit, and a frame reference.

In nibble mode the block sources an active-low frame marker. The marker lasts one nibble-clock period and covers the second nibble slot of the frame. In serial mode the block takes an external frame marker instead, and pulls its counter into line with that marker whenever the two disagree. In both modes the block captures the payload arriving from the terminal side, either four bits per nibble clock or one bit per transmit clock. It passes that payload to a downstream overhead inserter as a per-bit strobe and data bit. The strobe and bit follow the frame position one cycle late.

Top module: `ds3_txref`

## Requirements
- R1: During and immediately after synchronous active-low reset, `tx_pos` is 0, `ovh_gap` is 1, `nclk` is 0, `nib_frame_n` is 1, `pay_stb` is 0 and `realigned` is 0.
- R2: With no realignment, `tx_pos` advances by one every clock and wraps from BLOCK_BITS*BLOCKS-1 to 0. Position 0 is frame bit 1.
- R3: `ovh_gap` is 1 exactly when `tx_pos` mod BLOCK_BITS is 0, which is the overhead bit of a block.
- R4: Let q = (tx_pos mod BLOCK_BITS − 1) mod 4 on a payload position. `nclk` is 1 for q in {0,1} and 0 for q in {2,3}. On an overhead position it holds its low level. The result is (BLOCK_BITS−1)/4 nibble-clock periods per block.
- R5: When `nib_mode` was 1 in the previous cycle, `nib_frame_n` is 0 exactly on the four positions of the second nibble of block 0 (tx_pos 5..8). When `nib_mode` was 0, `nib_frame_n` stays 1.
- R6: `pay_stb` is 1 in the cycle after each payload position and 0 in the cycle after each overhead position. This gives (BLOCK_BITS−1)*BLOCKS strobes per frame.
- R7: In nibble mode, `nib_data_in` is sampled at the clock edge that ends a q=0 position, which is the cycle in which `nclk` rises. Its bits 3, 2, 1, 0 appear on `pay_data` in the cycles after the positions q=0, 1, 2, 3 of that nibble.
- R8: In serial mode, `ser_data_in` is sampled at every edge, and the value taken at the end of a payload position appears on `pay_data` in the next cycle.
- R9: In serial mode, when `ser_frame_in` is 1 while `tx_pos` is not 0, the next `tx_pos` is 1 and `realigned` becomes 1. When `ser_frame_in` is 1 while `tx_pos` is 0, counting is unchanged and the flag is not set.
- R10: In nibble mode, `ser_frame_in` has no effect on `tx_pos` or `realigned`.
- R11: Once set, `realigned` stays 1 until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 44.736 MHz transmit bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nib_mode | input | 1 | 1 selects the nibble interface, 0 the serial interface |
| ser_frame_in | input | 1 | External frame marker (serial mode), high on frame bit 1 |
| ser_data_in | input | 1 | Serial payload input |
| nib_data_in | input | 4 | Nibble payload input, bit 3 sent first |
| tx_pos | output | $clog2(BLOCK_BITS*BLOCKS) | Current frame bit position |
| ovh_gap | output | 1 | High on overhead bit positions |
| nclk | output | 1 | Gapped nibble clock |
| nib_frame_n | output | 1 | Active-low frame marker in nibble mode |
| pay_stb | output | 1 | Payload bit strobe to the overhead inserter |
| pay_data | output | 1 | Payload bit accompanying `pay_stb` |
| realigned | output | 1 | Sticky flag: serial frame marker moved the counter |

## Verification
The bench builds the block with BLOCK_BITS=9 and BLOCKS=4. This gives a 36-bit frame with two nibbles per block while keeping the overhead/payload structure and the second-nibble marker. At that size the bench can walk many whole frames in both modes. It can also realign the counter from every one of the 35 non-zero positions, and it can compare every output cycle against an arithmetic model of position, block offset and nibble phase.

// File: rtl/ds3_txref_pkg.sv
// Shared definitions for the DS3 transmit frame reference generator.
// Assumes 4-bit nibbles and a payload of a whole number of nibbles per block.
package ds3_txref_pkg;

    // Bit phase inside one nibble-clock period (q = 0..3)
    typedef enum logic [1:0] {
        PH0 = 2'd0,
        PH1 = 2'd1,
        PH2 = 2'd2,
        PH3 = 2'd3
    } nib_phase_e;

    // Zero-based nibble slot of block 0 that carries the nibble-mode frame marker
    localparam int FRAME_SLOT = 1;

    // Number of bits per nibble
    localparam int NIB_BITS = 4;

endpackage

// File: rtl/ds3_txref_cnt.sv
// Frame position counter for the transmit frame reference generator.
// Keeps the frame position, block offset, block index, nibble phase and
// nibble index as parallel counters, so no division is needed.
// Exposes both the current state and the next state; the next state lets
// the timing outputs be registered in step with the position.
// Assumes (BLOCK_BITS-1) is a multiple of 4 and gives at least two nibbles.
module ds3_txref_cnt
    import ds3_txref_pkg::*;
#(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 56,
    localparam int FRAME_BITS  = BLOCK_BITS * BLOCKS,
    localparam int POS_W       = $clog2(FRAME_BITS),
    localparam int OFF_W       = $clog2(BLOCK_BITS),
    localparam int BLK_W       = $clog2(BLOCKS),
    localparam int NIB_PER_BLK = (BLOCK_BITS - 1) / NIB_BITS,
    localparam int NIB_W       = $clog2(NIB_PER_BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             realign_req,
    output logic [POS_W-1:0] pos_q,
    output logic             cur_ovh,
    output nib_phase_e       cur_ph,
    output logic             nxt_ovh,
    output nib_phase_e       nxt_ph,
    output logic             nxt_blk_zero,
    output logic [NIB_W-1:0] nxt_nib,
    output logic             realigned
);

    logic [POS_W-1:0] pos_d;
    logic [OFF_W-1:0] off_q, off_d;
    logic [BLK_W-1:0] blk_q, blk_d;
    logic [NIB_W-1:0] nib_q, nib_d;
    nib_phase_e       ph_q, ph_d;
    logic             do_realign;
    logic             at_blk_end;
    logic             at_frm_end;

    assign at_blk_end = (off_q == OFF_W'(BLOCK_BITS - 1));
    assign at_frm_end = (pos_q == POS_W'(FRAME_BITS - 1));
    assign do_realign = realign_req && (pos_q != '0);

    // Next-state selection: realignment load, block wrap, overhead exit, or step
    always_comb begin
        pos_d = pos_q;
        off_d = off_q;
        blk_d = blk_q;
        nib_d = nib_q;
        ph_d  = ph_q;
        if (do_realign) begin
            pos_d = POS_W'(1);
            off_d = OFF_W'(1);
            blk_d = '0;
            nib_d = '0;
            ph_d  = PH0;
        end else begin
            pos_d = at_frm_end ? '0 : pos_q + 1'b1;
            if (at_blk_end) begin
                off_d = '0;
                blk_d = (blk_q == BLK_W'(BLOCKS - 1)) ? '0 : blk_q + 1'b1;
            end else if (off_q == '0) begin
                off_d = OFF_W'(1);
                nib_d = '0;
                ph_d  = PH0;
            end else begin
                off_d = off_q + 1'b1;
                ph_d  = nib_phase_e'(ph_q + 2'd1);
                if (ph_q == PH3) begin
                    nib_d = nib_q + 1'b1;
                end
            end
        end
    end

    // State registers; reset places the counter on frame bit 1 (overhead)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            off_q <= '0;
            blk_q <= '0;
            nib_q <= NIB_W'(NIB_PER_BLK - 1);
            ph_q  <= PH3;
        end else begin
            pos_q <= pos_d;
            off_q <= off_d;
            blk_q <= blk_d;
            nib_q <= nib_d;
            ph_q  <= ph_d;
        end
    end

    // Sticky record that an external frame marker moved the counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            realigned <= 1'b0;
        end else if (do_realign) begin
            realigned <= 1'b1;
        end
    end

    assign cur_ovh      = (off_q == '0);
    assign cur_ph       = ph_q;
    assign nxt_ovh      = (off_d == '0);
    assign nxt_ph       = ph_d;
    assign nxt_blk_zero = (blk_d == '0);
    assign nxt_nib      = nib_d;

endmodule

// File: rtl/ds3_txref_tim.sv
// Timing output stage: registers the gapped nibble clock, the overhead gap
// and the nibble-mode frame marker from the counter's next state, so these
// outputs line up with the registered frame position.
// Assumes the nibble phase is held at PH3 through every overhead bit.
module ds3_txref_tim
    import ds3_txref_pkg::*;
#(
    parameter int NIB_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_mode,
    input  logic             nxt_ovh,
    input  nib_phase_e       nxt_ph,
    input  logic             nxt_blk_zero,
    input  logic [NIB_W-1:0] nxt_nib,
    output logic             nclk,
    output logic             ovh_gap,
    output logic             nib_frame_n
);

    logic marker_slot;

    assign marker_slot = nib_mode && nxt_blk_zero && !nxt_ovh
                         && (nxt_nib == NIB_W'(FRAME_SLOT));

    // Glitch-free registered timing outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nclk        <= 1'b0;
            ovh_gap     <= 1'b1;
            nib_frame_n <= 1'b1;
        end else begin
            nclk        <= (nxt_ph == PH0) || (nxt_ph == PH1);
            ovh_gap     <= nxt_ovh;
            nib_frame_n <= !marker_slot;
        end
    end

endmodule

// File: rtl/ds3_txref_cap.sv
// Payload capture stage: takes serial bits every clock or a nibble when the
// nibble clock rises, and emits one payload bit with a strobe in the cycle
// after each payload position. The first nibble bit bypasses the hold
// register so the latency is one cycle in both modes.
// Assumes the source holds nibble data valid at the edge ending phase 0.
module ds3_txref_cap
    import ds3_txref_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nib_mode,
    input  logic       cur_ovh,
    input  nib_phase_e cur_ph,
    input  logic       ser_data_in,
    input  logic [3:0] nib_data_in,
    output logic       pay_stb,
    output logic       pay_data
);

    logic [2:0] nib_hold;
    logic       nib_bit;

    // Select the nibble bit belonging to the current phase, MSB first
    always_comb begin
        case (cur_ph)
            PH0:     nib_bit = nib_data_in[3];
            PH1:     nib_bit = nib_hold[2];
            PH2:     nib_bit = nib_hold[1];
            default: nib_bit = nib_hold[0];
        endcase
    end

    // Hold the remaining three nibble bits from the rising nibble-clock cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_hold <= '0;
        end else if (nib_mode && !cur_ovh && (cur_ph == PH0)) begin
            nib_hold <= nib_data_in[2:0];
        end
    end

    // Registered payload strobe and bit towards the overhead inserter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_stb  <= 1'b0;
            pay_data <= 1'b0;
        end else begin
            pay_stb  <= !cur_ovh;
            pay_data <= nib_mode ? nib_bit : ser_data_in;
        end
    end

endmodule

// File: rtl/ds3_txref.sv
// DS3 transmit frame reference generator, top level.
// Ties the frame counter, the timing output stage and the payload capture
// together. The serial frame marker only acts in serial mode.
// Assumes a single transmit bit clock domain and synchronous active-low reset.
module ds3_txref
    import ds3_txref_pkg::*;
#(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 56,
    localparam int FRAME_BITS  = BLOCK_BITS * BLOCKS,
    localparam int POS_W       = $clog2(FRAME_BITS),
    localparam int NIB_PER_BLK = (BLOCK_BITS - 1) / NIB_BITS,
    localparam int NIB_W       = $clog2(NIB_PER_BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_mode,
    input  logic             ser_frame_in,
    input  logic             ser_data_in,
    input  logic [3:0]       nib_data_in,
    output logic [POS_W-1:0] tx_pos,
    output logic             ovh_gap,
    output logic             nclk,
    output logic             nib_frame_n,
    output logic             pay_stb,
    output logic             pay_data,
    output logic             realigned
);

    logic             realign_req;
    logic             cur_ovh;
    nib_phase_e       cur_ph;
    logic             nxt_ovh;
    nib_phase_e       nxt_ph;
    logic             nxt_blk_zero;
    logic [NIB_W-1:0] nxt_nib;

    assign realign_req = !nib_mode && ser_frame_in;

    ds3_txref_cnt #(
        .BLOCK_BITS (BLOCK_BITS),
        .BLOCKS     (BLOCKS)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .realign_req  (realign_req),
        .pos_q        (tx_pos),
        .cur_ovh      (cur_ovh),
        .cur_ph       (cur_ph),
        .nxt_ovh      (nxt_ovh),
        .nxt_ph       (nxt_ph),
        .nxt_blk_zero (nxt_blk_zero),
        .nxt_nib      (nxt_nib),
        .realigned    (realigned)
    );

    ds3_txref_tim #(
        .NIB_W (NIB_W)
    ) u_tim (
        .clk          (clk),
        .rst_n        (rst_n),
        .nib_mode     (nib_mode),
        .nxt_ovh      (nxt_ovh),
        .nxt_ph       (nxt_ph),
        .nxt_blk_zero (nxt_blk_zero),
        .nxt_nib      (nxt_nib),
        .nclk         (nclk),
        .ovh_gap      (ovh_gap),
        .nib_frame_n  (nib_frame_n)
    );

    ds3_txref_cap u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .nib_mode    (nib_mode),
        .cur_ovh     (cur_ovh),
        .cur_ph      (cur_ph),
        .ser_data_in (ser_data_in),
        .nib_data_in (nib_data_in),
        .pay_stb     (pay_stb),
        .pay_data    (pay_data)
    );

endmodule

// File: rtl/ds3_txref_chk.sv
// Property checker for the DS3 transmit frame reference generator,
// attached to every instance of the top module by the bind below.
module ds3_txref_chk #(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 56,
    localparam int FRAME_BITS = BLOCK_BITS * BLOCKS,
    localparam int POS_W      = $clog2(FRAME_BITS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nib_mode,
    input logic             ser_frame_in,
    input logic [POS_W-1:0] tx_pos,
    input logic             ovh_gap,
    input logic             nclk,
    input logic             nib_frame_n,
    input logic             pay_stb,
    input logic             realigned
);

    logic moving;
    assign moving = !(!nib_mode && ser_frame_in && (tx_pos != '0));

    p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (moving && tx_pos != POS_W'(FRAME_BITS - 1)) |=> tx_pos == POS_W'($past(tx_pos) + 1'b1));

    p_pos_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (moving && tx_pos == POS_W'(FRAME_BITS - 1)) |=> tx_pos == '0);

    p_gap_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovh_gap == ((int'(tx_pos) % BLOCK_BITS) == 0));

    p_nclk_low_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovh_gap |-> !nclk);

    p_marker_serial_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !nib_mode |=> nib_frame_n);

    p_no_strobe_ovh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovh_gap |=> !pay_stb);

    p_realign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!nib_mode && ser_frame_in && tx_pos != '0) |=> (tx_pos == POS_W'(1) && realigned));

    p_nibble_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_mode && !realigned) |=> !realigned);

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        realigned |=> realigned);

endmodule

bind ds3_txref ds3_txref_chk #(
    .BLOCK_BITS (BLOCK_BITS),
    .BLOCKS     (BLOCKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .nib_mode     (nib_mode),
    .ser_frame_in (ser_frame_in),
    .tx_pos       (tx_pos),
    .ovh_gap      (ovh_gap),
    .nclk         (nclk),
    .nib_frame_n  (nib_frame_n),
    .pay_stb      (pay_stb),
    .realigned    (realigned)
);

// File: tb/test_ds3_txref.sv
// Self-checking bench: small frame (9-bit blocks, 4 blocks), cycle-by-cycle
// arithmetic model of position, offset, nibble phase and payload.
module test_ds3_txref;

    localparam int BB = 9;
    localparam int NB = 4;
    localparam int FB = BB * NB;
    localparam int PW = $clog2(FB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nib_mode = 1'b0;
    logic          ser_frame_in = 1'b0;
    logic          ser_data_in = 1'b0;
    logic [3:0]    nib_data_in = 4'h0;
    logic [PW-1:0] tx_pos;
    logic          ovh_gap;
    logic          nclk;
    logic          nib_frame_n;
    logic          pay_stb;
    logic          pay_data;
    logic          realigned;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    int   ep = 0;
    bit   eflag = 0;
    bit   prev_pay = 0;
    bit   prev_bit = 0;
    bit   prev_mode = 0;
    logic [3:0]  ncap = 4'h0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    ds3_txref #(
        .BLOCK_BITS (BB),
        .BLOCKS     (NB)
    ) i_ds3_txref (
        .clk          (clk),
        .rst_n        (rst_n),
        .nib_mode     (nib_mode),
        .ser_frame_in (ser_frame_in),
        .ser_data_in  (ser_data_in),
        .nib_data_in  (nib_data_in),
        .tx_pos       (tx_pos),
        .ovh_gap      (ovh_gap),
        .nclk         (nclk),
        .nib_frame_n  (nib_frame_n),
        .pay_stb      (pay_stb),
        .pay_data     (pay_data),
        .realigned    (realigned)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (pos %0d)", req, act, exp, ep);
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // One clock: check outputs at the negedge, drive inputs, advance the model
    task automatic step(input bit m, input bit fr);
        int off;
        int q;
        bit pay;
        off = ep % BB;
        q   = (off == 0) ? 0 : (off - 1) % 4;
        pay = (off != 0);
        check("R2 position", int'(tx_pos), ep);
        check("R3 overhead gap", int'(ovh_gap), int'(off == 0));
        check("R4 nibble clock", int'(nclk), int'(off != 0 && q < 2));
        check("R5 frame marker", int'(nib_frame_n),
              int'(!(prev_mode && (ep / BB) == 0 && off != 0 && ((off - 1) / 4) == 1)));
        check("R6 payload strobe", int'(pay_stb), int'(prev_pay));
        if (prev_pay) begin
            if (prev_mode) check("R7 nibble data", int'(pay_data), int'(prev_bit));
            else           check("R8 serial data", int'(pay_data), int'(prev_bit));
        end
        check("R11 sticky flag", int'(realigned), int'(eflag));
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        nib_mode     = m;
        ser_frame_in = fr;
        ser_data_in  = lfsr[0];
        nib_data_in  = lfsr[7:4];
        if (pay) begin
            if (m) begin
                if (q == 0) ncap = lfsr[7:4];
                prev_bit = ncap[3 - q];
            end else begin
                prev_bit = lfsr[0];
            end
        end
        prev_pay  = pay;
        prev_mode = m;
        @(posedge clk);
        if (!m && fr && ep != 0) begin
            ep    = 1;
            eflag = 1;
        end else begin
            ep = (ep + 1) % FB;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n        = 1'b0;
        ser_frame_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n     = 1'b1;
        ep        = 0;
        eflag     = 0;
        prev_pay  = 0;
        prev_mode = nib_mode;
        check("R1 reset pos", int'(tx_pos), 0);
        check("R1 reset gap", int'(ovh_gap), 1);
        check("R1 reset nclk", int'(nclk), 0);
        check("R1 reset marker", int'(nib_frame_n), 1);
        check("R1 reset strobe", int'(pay_stb), 0);
        check("R1 reset flag", int'(realigned), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_up();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // Nibble mode, with stray serial markers that must be ignored (R10)
        for (int i = 0; i < 3 * FB; i++) step(1'b1, (i % 7) == 3);
        check("R10 marker ignored flag", int'(realigned), 0);
        check("R10 marker ignored pos", int'(tx_pos), 0);
        // Serial mode, markers only on bit 1: counting unchanged (R9)
        for (int i = 0; i < 2 * FB; i++) step(1'b0, ep == 0);
        check("R9 aligned marker no flag", int'(realigned), 0);
        // Realign from every non-zero position (R9, R11)
        for (int k = 1; k < FB; k++) begin
            for (int j = 0; j < FB && ep != k; j++) step(1'b0, 1'b0);
            step(1'b0, 1'b1);
            check("R9 realign target", int'(tx_pos), 1);
            check("R9 realign flag", int'(realigned), 1);
        end
        for (int i = 0; i < FB; i++) step(1'b0, 1'b0);
        check("R11 flag held", int'(realigned), 1);
        // Reset clears the sticky flag, then one more nibble frame
        do_reset();
        check("R11 flag cleared by reset", int'(realigned), 0);
        for (int i = 0; i < 2 * FB; i++) step(1'b1, 1'b0);
        finish_up();
    end

endmodule